// File: doc/BRIEF.md
# Dual-bank serial LED channel driver

This block is the digital core of a 24-channel constant-current LED column driver that serves eight RGB pixels. A host sends a serial stream on one data pin, timed by a shift clock. A bank-select pin decides which of two shift chains takes each bit. One chain holds a 6-bit correction value for every channel, and the other holds an 8-bit brightness value for every channel. A falling edge on the active-low latch pin stores, for every channel, the product of its two values as a 14-bit level.

The cascade pin gives out the bit that leaves the selected chain, so several drivers can be chained. Each channel has a pulse-width output driven by a free-running 14-bit counter. The channel levels and the pulse outputs are forced to zero unless the driver-reset pin is high and the active-low enable pin is low. All pins are asynchronous to the system clock and pass through a synchronizer first. The latched levels are also brought out on a read-only parallel bus.

Top module: `led_colbank_drv`

## Requirements
- R1: After system reset (`rst_n` low), `chan_latched` is all zero, `sdo` is 0 and every `pwm_out` bit is 0. Both chains are cleared.
- R2: Each rising edge of the synchronized `sck` shifts one chain left by one bit, with `sdi` entering at bit 0. `bank_sel`=0 selects the 144-bit correction chain and `bank_sel`=1 selects the 192-bit brightness chain. Channel n uses correction bits [6n+5:6n] and brightness bits [8n+7:8n]. The last bits shifted in therefore belong to channel 0. Channels 3x, 3x+1 and 3x+2 are the blue, green and red parts of pixel x.
- R3: On each rising edge of `sck`, `sdo` takes the bit that leaves the selected chain: bit 143 of the correction chain or bit 191 of the brightness chain.
- R4: A high-to-low transition of `lat_n` loads every channel's 14-bit slice `chan_latched[14n+13:14n]` with its correction value times its brightness value. Shifting and rising `lat_n` edges leave `chan_latched` unchanged.
- R5: Shifting one chain leaves the other chain's contents unchanged.
- R6: `chan_level` equals `chan_latched` while `drv_rst_n`=1 and `en_n`=0. Otherwise `chan_level` is all zero.
- R7: While `drv_rst_n` is low, both chains and `chan_latched` keep their values, and shifting still works.
- R8: While `drv_rst_n` is low, the latch pin is treated as previously high. If `lat_n` is low when `drv_rst_n` rises, a capture takes place.
- R9: `pwm_out[n]` is high while the 14-bit free-running counter is below channel n's latched value and the outputs are enabled. Over any 16384 consecutive cycles it is high for exactly that value's count of cycles. It stays low while the outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sdi | input | 1 | Serial data pin |
| sck | input | 1 | Shift clock pin |
| bank_sel | input | 1 | Chain select pin: 0 selects correction, 1 selects brightness |
| lat_n | input | 1 | Active-low latch pin |
| drv_rst_n | input | 1 | Active-low driver reset pin |
| en_n | input | 1 | Active-low output enable pin |
| sdo | output | 1 | Cascade output |
| chan_latched | output | NCH*14 | Latched products, channel n at [14n+13:14n] |
| chan_level | output | NCH*14 | Gated channel levels |
| pwm_out | output | NCH | Per-channel pulse-width outputs |

## Verification
The bench builds the block with its default values: 24 channels and a two-stage synchronizer. With these values the chains are at their full length of 144 and 192 bits, so the bench can predict the complete cascade stream and every channel product. The 14-bit counter wraps after 16384 cycles, which is short enough for the bench to count a whole PWM period directly. Pins change only every few clock cycles, so the delay through the synchronizer never hides an edge.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  localparam int CORR_W = 6;
  localparam int BRT_W  = 8;
  localparam int PROD_W = CORR_W + BRT_W;

  function automatic logic [PROD_W-1:0] corr_mul(input logic [CORR_W-1:0] c,
                                                 input logic [BRT_W-1:0] b);
    logic [PROD_W-1:0] cw, bw;
    cw = {{BRT_W{1'b0}}, c};
    bw = {{CORR_W{1'b0}}, b};
    return cw * bw;
  endfunction
endpackage

// File: rtl/led_pin_sync.sv
module led_pin_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= pin_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/led_shift_banks.sv
module led_shift_banks #(
  parameter int NCH = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic sel,
  input  logic din,
  output logic [NCH*led_drv_pkg::CORR_W-1:0] bank0,
  output logic [NCH*led_drv_pkg::BRT_W-1:0]  bank1,
  output logic msb0,
  output logic msb1,
  output logic sdo
);
  localparam int L0 = NCH * led_drv_pkg::CORR_W;
  localparam int L1 = NCH * led_drv_pkg::BRT_W;

  assign msb0 = bank0[L0-1];
  assign msb1 = bank1[L1-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank0 <= '0;
      bank1 <= '0;
      sdo   <= 1'b0;
    end else if (shift_en) begin
      if (sel) begin
        sdo   <= msb1;
        bank1 <= {bank1[L1-2:0], din};
      end else begin
        sdo   <= msb0;
        bank0 <= {bank0[L0-2:0], din};
      end
    end
  end
endmodule

// File: rtl/led_chan_core.sv
module led_chan_core #(
  parameter int NCH = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NCH*led_drv_pkg::CORR_W-1:0] bank0,
  input  logic [NCH*led_drv_pkg::BRT_W-1:0]  bank1,
  input  logic lat_s,
  input  logic drv_rst_s,
  input  logic en_s,
  output logic [NCH*led_drv_pkg::PROD_W-1:0] latched,
  output logic [NCH*led_drv_pkg::PROD_W-1:0] level,
  output logic [NCH-1:0] pwm,
  output logic lat_fall,
  output logic out_active
);
  import led_drv_pkg::*;

  logic lat_prev;
  logic [PROD_W-1:0] pwm_cnt;

  assign lat_fall   = drv_rst_s & lat_prev & ~lat_s;
  assign out_active = drv_rst_s & ~en_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_prev <= 1'b1;
      pwm_cnt  <= '0;
    end else begin
      lat_prev <= drv_rst_s ? lat_s : 1'b1;
      pwm_cnt  <= pwm_cnt + 1'b1;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        latched[n*PROD_W +: PROD_W] <= '0;
      else if (lat_fall)
        latched[n*PROD_W +: PROD_W] <= corr_mul(bank0[n*CORR_W +: CORR_W],
                                                bank1[n*BRT_W +: BRT_W]);
    end
    assign level[n*PROD_W +: PROD_W] = out_active ? latched[n*PROD_W +: PROD_W] : '0;
    assign pwm[n] = out_active & (pwm_cnt < latched[n*PROD_W +: PROD_W]);
  end
endmodule

// File: rtl/led_colbank_drv.sv
module led_colbank_drv #(
  parameter int NCH = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdi,
  input  logic sck,
  input  logic bank_sel,
  input  logic lat_n,
  input  logic drv_rst_n,
  input  logic en_n,
  output logic sdo,
  output logic [NCH*led_drv_pkg::PROD_W-1:0] chan_latched,
  output logic [NCH*led_drv_pkg::PROD_W-1:0] chan_level,
  output logic [NCH-1:0] pwm_out
);
  import led_drv_pkg::*;

  localparam int NPIN = 6;

  logic [NPIN-1:0] pins_raw, pins_s;
  logic sdi_s, sck_s, sel_s, lat_s, drv_rst_s, en_s;
  logic sck_prev, sck_rise;
  logic msb0, msb1, lat_fall, out_active;
  logic [NCH*CORR_W-1:0] bank0;
  logic [NCH*BRT_W-1:0]  bank1;

  assign pins_raw = {en_n, drv_rst_n, lat_n, bank_sel, sck, sdi};
  assign {en_s, drv_rst_s, lat_s, sel_s, sck_s, sdi_s} = pins_s;

  led_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(6'b111000)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pins_raw), .pin_sync(pins_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_prev;

  led_shift_banks #(.NCH(NCH)) u_banks (
    .clk(clk), .rst_n(rst_n), .shift_en(sck_rise), .sel(sel_s), .din(sdi_s),
    .bank0(bank0), .bank1(bank1), .msb0(msb0), .msb1(msb1), .sdo(sdo));

  led_chan_core #(.NCH(NCH)) u_core (
    .clk(clk), .rst_n(rst_n), .bank0(bank0), .bank1(bank1),
    .lat_s(lat_s), .drv_rst_s(drv_rst_s), .en_s(en_s),
    .latched(chan_latched), .level(chan_level), .pwm(pwm_out),
    .lat_fall(lat_fall), .out_active(out_active));
endmodule

// File: rtl/led_colbank_drv_chk.sv
module led_colbank_drv_chk #(
  parameter int NCH = 24
) (
  input logic clk,
  input logic rst_n,
  input logic sck_rise,
  input logic sel_s,
  input logic msb0,
  input logic msb1,
  input logic sdo,
  input logic lat_fall,
  input logic out_active,
  input logic drv_rst_s,
  input logic [NCH*led_drv_pkg::CORR_W-1:0] bank0,
  input logic [NCH*led_drv_pkg::BRT_W-1:0]  bank1,
  input logic [NCH*led_drv_pkg::PROD_W-1:0] chan_latched,
  input logic [NCH*led_drv_pkg::PROD_W-1:0] chan_level,
  input logic [NCH-1:0] pwm_out
);
  import led_drv_pkg::*;

  function automatic logic all_in_range(input logic [NCH*PROD_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int n = 0; n < NCH; n++)
      if (int'(v[n*PROD_W +: PROD_W]) > ((1 << CORR_W) - 1) * ((1 << BRT_W) - 1)) ok = 1'b0;
    return ok;
  endfunction

  p_cascade_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> sdo == $past(sel_s ? msb1 : msb0));

  p_sdo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(sdo));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_fall |=> $stable(chan_latched));

  p_latch_ch0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lat_fall |=> chan_latched[PROD_W-1:0] ==
                 $past(corr_mul(bank0[CORR_W-1:0], bank1[BRT_W-1:0])));

  p_pwm_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_active |-> pwm_out == '0);

  p_level_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_active |-> chan_level == '0);

  p_drv_rst_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_rst_s |=> $stable(chan_latched));

  p_prod_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    all_in_range(chan_latched));
endmodule

bind led_colbank_drv led_colbank_drv_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sel_s(sel_s),
  .msb0(msb0), .msb1(msb1), .sdo(sdo), .lat_fall(lat_fall),
  .out_active(out_active), .drv_rst_s(drv_rst_s), .bank0(bank0), .bank1(bank1),
  .chan_latched(chan_latched), .chan_level(chan_level), .pwm_out(pwm_out));

// File: tb/led_colbank_drv_bench.sv
module led_colbank_drv_bench;
  localparam int NCH = 24;
  localparam int CW = 6;
  localparam int BW = 8;
  localparam int PW = 14;
  localparam int L0 = NCH * CW;
  localparam int L1 = NCH * BW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0, sck = 1'b0, bank_sel = 1'b0;
  logic lat_n = 1'b1, drv_rst_n = 1'b1, en_n = 1'b0;
  logic sdo;
  logic [NCH*PW-1:0] chan_latched, chan_level;
  logic [NCH-1:0] pwm_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  logic [L0-1:0] m0 = '0;
  logic [L1-1:0] m1 = '0;

  always #4 clk = ~clk;

  led_colbank_drv u_led_colbank_drv (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sck(sck), .bank_sel(bank_sel),
    .lat_n(lat_n), .drv_rst_n(drv_rst_n), .en_n(en_n), .sdo(sdo),
    .chan_latched(chan_latched), .chan_level(chan_level), .pwm_out(pwm_out));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [PW-1:0] exp_prod(input int n);
    return PW'(int'(m0[n*CW +: CW]) * int'(m1[n*BW +: BW]));
  endfunction

  function automatic logic [PW-1:0] got(input logic [NCH*PW-1:0] v, input int n);
    return v[n*PW +: PW];
  endfunction

  task automatic shift_bit(input logic sel, input logic b, output logic out);
    bank_sel = sel; sdi = b; tick(5);
    sck = 1'b1; tick(5);
    out = sdo;
    sck = 1'b0; tick(5);
    if (sel) m1 = {m1[L1-2:0], b};
    else     m0 = {m0[L0-2:0], b};
  endtask

  task automatic load_bank0(input int seed);
    logic [L0-1:0] v;
    logic o;
    for (int n = 0; n < NCH; n++) v[n*CW +: CW] = CW'((n * seed + 3) % 64);
    for (int k = L0 - 1; k >= 0; k--) shift_bit(1'b0, v[k], o);
  endtask

  task automatic load_bank1(input int seed);
    logic [L1-1:0] v;
    logic o;
    for (int n = 0; n < NCH; n++) v[n*BW +: BW] = BW'((n * seed + 11) % 256);
    for (int k = L1 - 1; k >= 0; k--) shift_bit(1'b1, v[k], o);
  endtask

  task automatic check_all_latched(input string tag);
    int bad = 0;
    int first = -1;
    for (int n = 0; n < NCH; n++)
      if (got(chan_latched, n) !== exp_prod(n)) begin
        bad++;
        if (first < 0) first = n;
      end
    if (first < 0) first = 0;
    check(bad == 0, tag, longint'(got(chan_latched, first)), longint'(exp_prod(first)));
  endtask

  task automatic t_reset();
    check(chan_latched == '0, "R1 latched zero after reset", longint'(got(chan_latched, 0)), 0);
    check(sdo == 1'b0, "R1 sdo low after reset", longint'(sdo), 0);
    check(pwm_out == '0, "R1 pwm low after reset", longint'(pwm_out), 0);
  endtask

  task automatic t_load();
    load_bank0(5);
    load_bank1(37);
    check(chan_latched == '0, "R4 no capture before latch fall", longint'(got(chan_latched, 0)), 0);
    lat_n = 1'b0; tick(6);
    check_all_latched("R4 products after latch fall");
    check(got(chan_latched, 0) == 14'(3 * 11), "R2 channel 0 (pixel 0 blue) from last bits",
          longint'(got(chan_latched, 0)), 33);
    check(got(chan_latched, 23) == 14'(((23*5+3)%64) * ((23*37+11)%256)),
          "R2 channel 23 (pixel 7 red) from first bits",
          longint'(got(chan_latched, 23)), longint'(((23*5+3)%64) * ((23*37+11)%256)));
    check(chan_level == chan_latched, "R6 level follows latched when active",
          longint'(got(chan_level, 1)), longint'(got(chan_latched, 1)));
    lat_n = 1'b1; tick(6);
    check_all_latched("R4 rising latch edge leaves values");
  endtask

  task automatic t_gate();
    logic [NCH*PW-1:0] keep;
    keep = chan_latched;
    en_n = 1'b1; tick(6);
    check(chan_level == '0, "R6 level zero when disabled", longint'(got(chan_level, 1)), 0);
    check(pwm_out == '0, "R9 pwm low when disabled", longint'(pwm_out), 0);
    en_n = 1'b0; drv_rst_n = 1'b0; tick(6);
    check(chan_level == '0, "R6 level zero in driver reset", longint'(got(chan_level, 1)), 0);
    check(chan_latched == keep, "R7 driver reset keeps latched",
          longint'(got(chan_latched, 1)), longint'(got(keep, 1)));
    drv_rst_n = 1'b1; tick(6);
    check(chan_level == keep, "R6 level restored after driver reset",
          longint'(got(chan_level, 1)), longint'(got(keep, 1)));
  endtask

  task automatic t_pwm(input int ch);
    int hi = 0;
    for (int i = 0; i < 16384; i++) begin
      tick(1);
      if (pwm_out[ch]) hi++;
    end
    check(hi == int'(exp_prod(ch)), $sformatf("R9 pwm duty channel %0d", ch), hi, longint'(exp_prod(ch)));
  endtask

  task automatic t_pwm_off();
    int hi = 0;
    en_n = 1'b1; tick(6);
    for (int i = 0; i < 300; i++) begin
      tick(1);
      if (pwm_out != '0) hi++;
    end
    check(hi == 0, "R9 pwm stays low when disabled", hi, 0);
    en_n = 1'b0; tick(6);
  endtask

  task automatic t_cascade();
    int bad = 0;
    logic o, e;
    for (int k = 0; k < L0; k++) begin
      e = m0[L0-1];
      shift_bit(1'b0, 1'b0, o);
      if (o !== e) bad++;
    end
    check(bad == 0, "R3 cascade stream of correction chain", bad, 0);
    lat_n = 1'b0; tick(6); lat_n = 1'b1; tick(6);
    check(chan_latched == '0, "R5 zero correction gives zero products", longint'(got(chan_latched, 3)), 0);
    load_bank0(5);
    lat_n = 1'b0; tick(6); lat_n = 1'b1; tick(6);
    check_all_latched("R5 brightness chain kept while correction shifted");
    e = m1[L1-1];
    shift_bit(1'b1, 1'b0, o);
    check(o == e, "R3 cascade bit of brightness chain", longint'(o), longint'(e));
  endtask

  task automatic t_rearm();
    logic [NCH*PW-1:0] keep;
    lat_n = 1'b0; tick(6);
    check_all_latched("R4 capture before rearm test");
    keep = chan_latched;
    drv_rst_n = 1'b0; tick(6);
    load_bank0(11);
    check(chan_latched == keep, "R7 shifting in driver reset keeps latched",
          longint'(got(chan_latched, 2)), longint'(got(keep, 2)));
    drv_rst_n = 1'b1; tick(6);
    check_all_latched("R8 capture on driver reset release with latch low");
    lat_n = 1'b1; tick(6);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_load();
    t_gate();
    t_pwm(5);
    t_pwm(0);
    t_pwm_off();
    t_cascade();
    t_rearm();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule